// File: doc/BRIEF.md
# Interrupt, Halt and Bus-Qualifier Sequencer

This block is the control slice of an 8-bit processor that takes the core into its exception entry and holds it in the two halt states. Reset, an active-low abort line, a falling-edge NMI, a level IRQ and the BRK instruction all share one entry sequence. The sequence makes three stack cycles, one for each of the return address high byte, the return address low byte and the status byte. It then reads a two-byte handler address from a vector chosen by the source. WAI and STP requests from the instruction decoder park the core until an allowed wake-up event arrives.

Every bus cycle carries a five-bit qualifier (vector, base-page, stack, data, program, from MSB to LSB). External memory logic can use it to route stack, zero-page and vector traffic to separate storage. When the sequencer is not in control, the decoder's own cycle kind, address and write strobe pass through and receive the matching code. Stack-relative accesses that do not move the stack pointer therefore still appear as stack cycles.

Top module: `irq_halt_sequencer`

## Requirements
- R1: While rst_n is low, qual is 00000, we is 0 and halted is 0. The first rising edge after release starts an entry whose three stack cycles are reads (we=0) at {0x01,sp}, {0x01,sp-1} and {0x01,sp-2}, all with qual 10110.
- R2: The last two cycles of every entry read the vector low byte and then the high byte, with qual 10010. During the high-byte cycle pc_load is 1 and pc_new = {data_in, low byte latched in the previous cycle}. Reset uses 0xFFFC/0xFFFD.
- R3: Outside entry and halt, qual follows core_kind (0 internal 00000, 1 opcode 00001, 2 operand 00011, 3 data 00010, 4 base-page 01010, 5 stack 00110), and addr, we and wdata pass through from the core.
- R4: IRQ low with i_flag=0 at an instruction boundary starts an entry on the next edge. The entry writes pc_in[15:8], then pc_in[7:0], then status_in, each with qual 10110, asserts set_i during the status push, and then reads 0xFFFE/0xFFFF.
- R5: IRQ is ignored while i_flag=1, and the core cycles keep passing through.
- R6: A falling edge on abort_n is acted on at the first rising edge that samples it low, with or without a boundary. The entry uses vector 0xFFF8/0xFFF9.
- R7: A falling edge on nmi_n is taken at a boundary even when i_flag=1, and uses 0xFFFA/0xFFFB. Holding nmi_n low does not start a second entry.
- R8: brk_req starts an entry with pushes and vector 0xFFFE.
- R9: wai_req halts the core (halted=1, qual 00000). IRQ with i_flag=1 leaves it halted, and IRQ with i_flag=0 wakes it straight into IRQ entry.
- R10: An NMI edge wakes a WAI halt into NMI entry.
- R11: stp_req halts the core. IRQ and NMI leave it halted, and only abort (or reset) releases it, into abort entry.
- R12: Priority is abort, then NMI, then IRQ. A lower-priority edge that loses is held pending and taken at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-2 clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 1 | Level interrupt request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensed |
| abort_n | input | 1 | Abort, falling-edge sensed |
| i_flag | input | 1 | Interrupt-disable flag |
| boundary | input | 1 | Current cycle ends an instruction |
| brk_req | input | 1 | Decoder requests BRK entry |
| wai_req | input | 1 | Decoder requests WAI halt |
| stp_req | input | 1 | Decoder requests STP halt |
| sp_in | input | 8 | Stack pointer |
| pc_in | input | 16 | Return address to push |
| status_in | input | 8 | Status byte to push |
| data_in | input | 8 | Read data bus |
| core_kind | input | 3 | Decoder cycle kind |
| core_addr | input | 16 | Decoder address |
| core_we | input | 1 | Decoder write strobe |
| core_wdata | input | 8 | Decoder write data |
| qual | output | 5 | Cycle qualifier: vector, base, stack, data, program |
| addr | output | 16 | Bus address |
| we | output | 1 | Bus write strobe |
| wdata | output | 8 | Bus write data |
| set_i | output | 1 | Set the interrupt-disable flag |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | 16 | Handler address |
| halted | output | 1 | Core is in WAI or STP |

## Verification
A request sampled at a rising edge shows up in the outputs of the cycle that edge opens. The first push therefore appears one cycle after the trigger, and the five entry cycles follow back to back, with pc_load in the fifth. The same one-cycle rule applies to entering and leaving a halt. Pass-through codes are combinational and are due in the same cycle. The bench changes inputs on falling edges and compares on the next falling edge, a half period after the edge that must produce the result. During the high-vector cycle it drives data_in and waits a short delay before comparing pc_new.

// File: rtl/isq_pkg.sv
package isq_pkg;
   typedef enum logic [3:0] {
      S_RST, S_RUN, S_WAI, S_STP, S_PSH_H, S_PSH_L, S_PSH_P, S_VEC_L, S_VEC_H
   } isq_state_e;

   typedef enum logic [1:0] {SRC_RST, SRC_ABT, SRC_NMI, SRC_IRQ} isq_src_e;

   localparam logic [4:0] Q_INT   = 5'b00000;
   localparam logic [4:0] Q_OPC   = 5'b00001;
   localparam logic [4:0] Q_OPR   = 5'b00011;
   localparam logic [4:0] Q_DATA  = 5'b00010;
   localparam logic [4:0] Q_BASE  = 5'b01010;
   localparam logic [4:0] Q_STACK = 5'b00110;
   localparam logic [4:0] Q_ENTRY = 5'b10110;
   localparam logic [4:0] Q_VEC   = 5'b10010;

   function automatic logic [4:0] kind_to_qual(input logic [2:0] kind);
      case (kind)
         3'd1:    return Q_OPC;
         3'd2:    return Q_OPR;
         3'd3:    return Q_DATA;
         3'd4:    return Q_BASE;
         3'd5:    return Q_STACK;
         default: return Q_INT;
      endcase
   endfunction
endpackage

// File: rtl/isq_arbiter.sv
module isq_arbiter
   import isq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort_n,
   input  logic       nmi_n,
   input  logic       irq_n,
   input  logic       i_flag,
   input  logic       boundary,
   input  logic       brk_req,
   input  logic       wai_req,
   input  logic       stp_req,
   input  isq_state_e state,
   output logic       go,
   output isq_src_e   go_src,
   output logic       go_wai,
   output logic       go_stp
);
   logic abt_prev, nmi_prev, abt_pend, nmi_pend;
   logic abt_hit, nmi_hit, abt_any, nmi_any, irq_on;

   assign abt_hit = abt_prev & ~abort_n;
   assign nmi_hit = nmi_prev & ~nmi_n;
   assign abt_any = abt_hit | abt_pend;
   assign nmi_any = nmi_hit | nmi_pend;
   assign irq_on  = ~irq_n & ~i_flag;

   always_comb begin
      go     = 1'b0;
      go_src = SRC_IRQ;
      go_wai = 1'b0;
      go_stp = 1'b0;
      case (state)
         S_RUN: begin
            if (abt_any) begin
               go = 1'b1; go_src = SRC_ABT;
            end else if (boundary && nmi_any) begin
               go = 1'b1; go_src = SRC_NMI;
            end else if (boundary && irq_on) begin
               go = 1'b1; go_src = SRC_IRQ;
            end else if (brk_req) begin
               go = 1'b1; go_src = SRC_IRQ;
            end else if (stp_req) begin
               go_stp = 1'b1;
            end else if (wai_req) begin
               go_wai = 1'b1;
            end
         end
         S_WAI: begin
            if (abt_any) begin
               go = 1'b1; go_src = SRC_ABT;
            end else if (nmi_any) begin
               go = 1'b1; go_src = SRC_NMI;
            end else if (irq_on) begin
               go = 1'b1; go_src = SRC_IRQ;
            end
         end
         S_STP: begin
            if (abt_any) begin
               go = 1'b1; go_src = SRC_ABT;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abt_prev <= 1'b1;
         nmi_prev <= 1'b1;
         abt_pend <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         abt_prev <= abort_n;
         nmi_prev <= nmi_n;
         abt_pend <= abt_any & ~(go && go_src == SRC_ABT);
         nmi_pend <= nmi_any & ~(go && go_src == SRC_NMI);
      end
   end
endmodule

// File: rtl/isq_fsm.sv
module isq_fsm
   import isq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  isq_src_e          go_src,
   input  logic              go_wai,
   input  logic              go_stp,
   input  logic [DATA_W-1:0] data_in,
   output isq_state_e        state,
   output isq_src_e          src,
   output logic [DATA_W-1:0] vec_lo
);
   isq_state_e state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         S_RST:   state_nx = S_PSH_H;
         S_RUN, S_WAI, S_STP: begin
            if (go)          state_nx = S_PSH_H;
            else if (go_stp) state_nx = S_STP;
            else if (go_wai) state_nx = S_WAI;
         end
         S_PSH_H: state_nx = S_PSH_L;
         S_PSH_L: state_nx = S_PSH_P;
         S_PSH_P: state_nx = S_VEC_L;
         S_VEC_L: state_nx = S_VEC_H;
         S_VEC_H: state_nx = S_RUN;
         default: state_nx = S_RST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_RST;
         src    <= SRC_RST;
         vec_lo <= '0;
      end else begin
         state <= state_nx;
         if (go) src <= go_src;
         if (state == S_VEC_L) vec_lo <= data_in;
      end
   end
endmodule

// File: rtl/isq_busq.sv
module isq_busq
   import isq_pkg::*;
#(
   parameter int                 DATA_W       = 8,
   parameter int                 ADDR_W       = 16,
   parameter logic [DATA_W-1:0]  STACK_PAGE   = 8'h01,
   parameter logic [ADDR_W-1:0]  VEC_RST      = 16'hFFFC,
   parameter logic [ADDR_W-1:0]  VEC_ABT      = 16'hFFF8,
   parameter logic [ADDR_W-1:0]  VEC_NMI      = 16'hFFFA,
   parameter logic [ADDR_W-1:0]  VEC_IRQ      = 16'hFFFE,
   parameter bit                 RESET_WRITES = 1'b0
) (
   input  isq_state_e        state,
   input  isq_src_e          src,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] vec_lo,
   input  logic [2:0]        core_kind,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_we,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [4:0]        qual,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic [DATA_W-1:0] wdata,
   output logic              set_i,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic              halted
);
   logic              push_we;
   logic [ADDR_W-1:0] vec_base;

   generate
      if (RESET_WRITES) begin : g_rst_wr
         assign push_we = 1'b1;
      end else begin : g_rst_rd
         assign push_we = (src != SRC_RST);
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_RST: vec_base = VEC_RST;
         SRC_ABT: vec_base = VEC_ABT;
         SRC_NMI: vec_base = VEC_NMI;
         default: vec_base = VEC_IRQ;
      endcase
   end

   assign pc_new = {data_in, vec_lo};

   always_comb begin
      qual    = Q_INT;
      addr    = core_addr;
      we      = 1'b0;
      wdata   = core_wdata;
      set_i   = 1'b0;
      pc_load = 1'b0;
      halted  = 1'b0;
      case (state)
         S_RUN: begin
            qual = kind_to_qual(core_kind);
            we   = core_we;
         end
         S_WAI, S_STP: halted = 1'b1;
         S_PSH_H: begin
            qual  = Q_ENTRY;
            addr  = {STACK_PAGE, sp_in};
            we    = push_we;
            wdata = pc_in[ADDR_W-1:DATA_W];
         end
         S_PSH_L: begin
            qual  = Q_ENTRY;
            addr  = {STACK_PAGE, sp_in - DATA_W'(1)};
            we    = push_we;
            wdata = pc_in[DATA_W-1:0];
         end
         S_PSH_P: begin
            qual  = Q_ENTRY;
            addr  = {STACK_PAGE, sp_in - DATA_W'(2)};
            we    = push_we;
            wdata = status_in;
            set_i = 1'b1;
         end
         S_VEC_L: begin
            qual = Q_VEC;
            addr = vec_base;
         end
         S_VEC_H: begin
            qual    = Q_VEC;
            addr    = vec_base | ADDR_W'(1);
            pc_load = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/irq_halt_sequencer.sv
module irq_halt_sequencer
   import isq_pkg::*;
#(
   parameter int                 DATA_W       = 8,
   parameter int                 ADDR_W       = 16,
   parameter logic [DATA_W-1:0]  STACK_PAGE   = 8'h01,
   parameter logic [ADDR_W-1:0]  VEC_RST      = 16'hFFFC,
   parameter logic [ADDR_W-1:0]  VEC_ABT      = 16'hFFF8,
   parameter logic [ADDR_W-1:0]  VEC_NMI      = 16'hFFFA,
   parameter logic [ADDR_W-1:0]  VEC_IRQ      = 16'hFFFE,
   parameter bit                 RESET_WRITES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_n,
   input  logic              nmi_n,
   input  logic              abort_n,
   input  logic              i_flag,
   input  logic              boundary,
   input  logic              brk_req,
   input  logic              wai_req,
   input  logic              stp_req,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [2:0]        core_kind,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_we,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [4:0]        qual,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic [DATA_W-1:0] wdata,
   output logic              set_i,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic              halted
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("irq_halt_sequencer: ADDR_W must be twice DATA_W");
      end
      if (VEC_RST[0] || VEC_ABT[0] || VEC_NMI[0] || VEC_IRQ[0]) begin : g_bad_vec
         $error("irq_halt_sequencer: vectors must be even");
      end
   endgenerate

   isq_state_e        state;
   isq_src_e          src, go_src;
   logic              go, go_wai, go_stp;
   logic [DATA_W-1:0] vec_lo;

   isq_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .nmi_n(nmi_n),
      .irq_n(irq_n), .i_flag(i_flag), .boundary(boundary),
      .brk_req(brk_req), .wai_req(wai_req), .stp_req(stp_req),
      .state(state), .go(go), .go_src(go_src), .go_wai(go_wai),
      .go_stp(go_stp)
   );

   isq_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .go_src(go_src),
      .go_wai(go_wai), .go_stp(go_stp), .data_in(data_in),
      .state(state), .src(src), .vec_lo(vec_lo)
   );

   isq_busq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STACK_PAGE(STACK_PAGE),
      .VEC_RST(VEC_RST), .VEC_ABT(VEC_ABT), .VEC_NMI(VEC_NMI),
      .VEC_IRQ(VEC_IRQ), .RESET_WRITES(RESET_WRITES)
   ) u_busq (
      .state(state), .src(src), .sp_in(sp_in), .pc_in(pc_in),
      .status_in(status_in), .data_in(data_in), .vec_lo(vec_lo),
      .core_kind(core_kind), .core_addr(core_addr), .core_we(core_we),
      .core_wdata(core_wdata), .qual(qual), .addr(addr), .we(we),
      .wdata(wdata), .set_i(set_i), .pc_load(pc_load), .pc_new(pc_new),
      .halted(halted)
   );
endmodule

// File: rtl/irq_halt_sequencer_chk.sv
module irq_halt_sequencer_chk
   import isq_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort_n,
   input logic [4:0]        qual,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic              set_i,
   input logic              pc_load,
   input logic              halted
);
   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (qual == Q_INT && !we));

   assert_vec_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (qual == Q_VEC) |-> (addr[ADDR_W-1:4] == '1));

   assert_pc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (qual == Q_VEC && addr[0]));

   assert_set_i_then_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (qual == Q_VEC && !addr[0]));

   assert_entry_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (qual == Q_ENTRY) |=> (qual == Q_ENTRY || qual == Q_VEC));

   assert_abort_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && $fell(abort_n)) |=> (!halted && qual == Q_ENTRY));
endmodule

bind irq_halt_sequencer irq_halt_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .qual(qual), .addr(addr),
   .we(we), .set_i(set_i), .pc_load(pc_load), .halted(halted)
);

// File: tb/irq_halt_sequencer_test.sv
module irq_halt_sequencer_test;
   logic        clk = 1'b0;
   logic        rst_n, irq_n, nmi_n, abort_n, i_flag, boundary;
   logic        brk_req, wai_req, stp_req, core_we;
   logic [7:0]  sp_in, status_in, data_in, core_wdata;
   logic [15:0] pc_in, core_addr;
   logic [2:0]  core_kind;
   logic [4:0]  qual;
   logic [15:0] addr, pc_new;
   logic        we, set_i, pc_load, halted;
   logic [7:0]  wdata;
   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_halt_sequencer uut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
      .abort_n(abort_n), .i_flag(i_flag), .boundary(boundary),
      .brk_req(brk_req), .wai_req(wai_req), .stp_req(stp_req),
      .sp_in(sp_in), .pc_in(pc_in), .status_in(status_in),
      .data_in(data_in), .core_kind(core_kind), .core_addr(core_addr),
      .core_we(core_we), .core_wdata(core_wdata), .qual(qual),
      .addr(addr), .we(we), .wdata(wdata), .set_i(set_i),
      .pc_load(pc_load), .pc_new(pc_new), .halted(halted)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Five-cycle entry; the trigger was applied before the coming rising edge.
   task automatic entry(input string req, input logic exp_we, input logic [15:0] vec);
      @(negedge clk);
      abort_n = 1'b1; brk_req = 1'b0; boundary = 1'b0; wai_req = 1'b0; stp_req = 1'b0;
      chk({req, " push hi qual"}, qual, 5'b10110);
      chk({req, " push hi addr"}, addr, {8'h01, sp_in});
      chk({req, " push hi we"}, we, exp_we);
      if (exp_we) chk({req, " push hi data"}, wdata, pc_in[15:8]);
      @(negedge clk);
      chk({req, " push lo addr"}, addr, {8'h01, sp_in - 8'd1});
      chk({req, " push lo we"}, we, exp_we);
      if (exp_we) chk({req, " push lo data"}, wdata, pc_in[7:0]);
      @(negedge clk);
      chk({req, " push p addr"}, addr, {8'h01, sp_in - 8'd2});
      chk({req, " push p set_i"}, set_i, 1'b1);
      if (exp_we) chk({req, " push p data"}, wdata, status_in);
      @(negedge clk);
      chk({req, " vec lo qual"}, qual, 5'b10010);
      chk({req, " vec lo addr"}, addr, vec);
      data_in = 8'h34;
      @(negedge clk);
      data_in = 8'h12;
      #1;
      chk({req, " vec hi addr"}, addr, vec + 16'd1);
      chk({req, " pc_load"}, pc_load, 1'b1);
      chk({req, " pc_new"}, pc_new, 16'h1234);
      @(negedge clk);
      chk({req, " back to run"}, {pc_load, halted, qual}, {2'b00, 5'b00000});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {qual, we, halted}, 7'b0);
      rst_n = 1'b1;
      entry("R1 R2 reset", 1'b0, 16'hFFFC);
   endtask

   task automatic t_core_pass;
      for (int k = 0; k < 6; k++) begin
         logic [4:0] e;
         case (k)
            0: e = 5'b00000; 1: e = 5'b00001; 2: e = 5'b00011;
            3: e = 5'b00010; 4: e = 5'b01010; default: e = 5'b00110;
         endcase
         @(negedge clk);
         core_kind = 3'(k); core_addr = 16'h0200 + 16'(k); core_we = k[0];
         #1;
         chk("R3 qual", qual, e);
         chk("R3 addr/we", {addr, we}, {16'h0200 + 16'(k), k[0]});
      end
      @(negedge clk);
      core_kind = 3'd0; core_we = 1'b0;
   endtask

   task automatic t_irq_masked;
      @(negedge clk);
      i_flag = 1'b1; irq_n = 1'b0; boundary = 1'b1; core_kind = 3'd1;
      repeat (2) begin
         @(negedge clk);
         chk("R5 masked irq passes core", {qual, halted}, {5'b00001, 1'b0});
      end
      irq_n = 1'b1; boundary = 1'b0; core_kind = 3'd0;
   endtask

   task automatic t_irq;
      @(negedge clk);
      i_flag = 1'b0; irq_n = 1'b0; boundary = 1'b1;
      entry("R4 irq", 1'b1, 16'hFFFE);
      irq_n = 1'b1; i_flag = 1'b1;
   endtask

   task automatic t_brk;
      @(negedge clk);
      brk_req = 1'b1;
      entry("R8 brk", 1'b1, 16'hFFFE);
   endtask

   task automatic t_nmi;
      @(negedge clk);
      i_flag = 1'b1; nmi_n = 1'b0; boundary = 1'b1;
      entry("R7 nmi", 1'b1, 16'hFFFA);
      boundary = 1'b1;
      repeat (2) begin
         @(negedge clk);
         chk("R7 held nmi no retrigger", qual, 5'b00000);
      end
      boundary = 1'b0; nmi_n = 1'b1;
   endtask

   task automatic t_abort;
      @(negedge clk);
      abort_n = 1'b0; boundary = 1'b0;
      entry("R6 abort", 1'b1, 16'hFFF8);
   endtask

   task automatic t_wai_irq;
      @(negedge clk);
      wai_req = 1'b1; boundary = 1'b1;
      @(negedge clk);
      wai_req = 1'b0; boundary = 1'b0;
      chk("R9 wai halted", {halted, qual}, {1'b1, 5'b00000});
      i_flag = 1'b1; irq_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R9 masked irq keeps halt", halted, 1'b1);
      end
      i_flag = 1'b0;
      entry("R9 wai irq wake", 1'b1, 16'hFFFE);
      irq_n = 1'b1; i_flag = 1'b1;
   endtask

   task automatic t_wai_nmi;
      @(negedge clk);
      wai_req = 1'b1; boundary = 1'b1;
      @(negedge clk);
      wai_req = 1'b0; boundary = 1'b0;
      chk("R10 wai halted", halted, 1'b1);
      nmi_n = 1'b0;
      entry("R10 wai nmi wake", 1'b1, 16'hFFFA);
      nmi_n = 1'b1;
   endtask

   task automatic t_stp;
      @(negedge clk);
      stp_req = 1'b1; boundary = 1'b1;
      @(negedge clk);
      stp_req = 1'b0; boundary = 1'b0;
      chk("R11 stp halted", halted, 1'b1);
      i_flag = 1'b0; irq_n = 1'b0; nmi_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R11 irq/nmi ignored in stp", {halted, qual}, {1'b1, 5'b00000});
      end
      irq_n = 1'b1; i_flag = 1'b1;
      abort_n = 1'b0;
      entry("R11 stp abort wake", 1'b1, 16'hFFF8);
      nmi_n = 1'b1;
      boundary = 1'b1;
      entry("R12 pending nmi after stp", 1'b1, 16'hFFFA);
   endtask

   task automatic t_prio;
      @(negedge clk);
      abort_n = 1'b0; nmi_n = 1'b0; boundary = 1'b1;
      entry("R12 abort over nmi", 1'b1, 16'hFFF8);
      nmi_n = 1'b1; boundary = 1'b1;
      entry("R12 nmi pending taken", 1'b1, 16'hFFFA);
      @(negedge clk);
      nmi_n = 1'b0; irq_n = 1'b0; i_flag = 1'b0; boundary = 1'b1;
      entry("R12 nmi over irq", 1'b1, 16'hFFFA);
      irq_n = 1'b1; i_flag = 1'b1; nmi_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; abort_n = 1'b1; i_flag = 1'b1;
      boundary = 1'b0; brk_req = 1'b0; wai_req = 1'b0; stp_req = 1'b0;
      sp_in = 8'hF0; pc_in = 16'hABCD; status_in = 8'h5A; data_in = 8'h00;
      core_kind = 3'd0; core_addr = 16'h0000; core_we = 1'b0; core_wdata = 8'h00;
      t_reset();
      t_core_pass();
      t_irq_masked();
      t_irq();
      t_brk();
      t_nmi();
      t_abort();
      t_wai_irq();
      t_wai_nmi();
      t_stp();
      t_prio();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule